// File: doc/BRIEF.md
# Interleave Duty-Cycle Skew Trimmer

This controller equalises the share of each clock period during which each of the two interleaved sub-converters drives the output. While it runs, it holds one sub-converter at full scale and the other at zero. The summed output then becomes a square wave, and its averaged level follows the duty cycle. An external averager and comparator report a single sign, which says whether that level lies above the mid-level. The controller moves two 6-bit delay words, one for each clock edge, one step at a time. It stops when the sign flips or when the word it is moving reaches its top code.

Each run has two passes. In the first pass sub-converter A is held high. In the second pass the roles are swapped, so sub-converter B is held high. Each pass starts from mid-code. The final pair of delay words is the floor average of the two pass results, which cancels the offset that depends on which sub-converter is held high. Start the controller only after the amplitudes of the two sub-converters have been matched, because the averaged level also depends on amplitude. After each code change, the controller waits a programmable settling time so that the external average can follow the change before the sign is read.

The controller has four states, and the pass register and the first-sample flag qualify them:
- ST_IDLE holds the last result. A start request moves it to ST_SETTLE with pass FWD, both words at mid-code and the settle time latched.
- ST_SETTLE counts the settle time and then moves to ST_SAMPLE.
- ST_SAMPLE reads the sign and takes one of three transitions:
  - step: it moves one word up by one and returns to ST_SETTLE.
  - pass switch (FWD to SWP): it stores the words, reloads mid-code and returns to ST_SETTLE.
  - finish: at the end of the SWP pass it loads the averages and moves to ST_DONE.
- ST_DONE gives a one-cycle completion pulse and then returns to ST_IDLE.

Top module: `skew_trim_ctrl`

## Requirements
- R1: Reset state. After reset, both delay words equal mid-code 32, busy and done are low, and both forced codes are zero.
- R2: Forced codes.
  - In the first pass, force_a is all ones (4095) and force_b is zero.
  - In the second pass, force_a is zero and force_b is all ones.
  - Whenever busy is low, both forced codes are zero.
- R3: Both delay words equal 32 at the start of each pass.
- R4: Settle timing. With settle length W, the controller samples the comparator only after the delay words have held for W+1 settle cycles. Consecutive code changes are therefore exactly W+2 cycles apart. A run made of S samples in total finishes with done high S*(W+2) cycles after the start edge.
- R5: Stepping.
  - The first sample of a pass records the reference sign.
  - In the first pass, a high sign steps dly_a up by one and a low sign steps dly_b up by one.
  - In the second pass, a high sign steps dly_b and a low sign steps dly_a.
  - Each step changes exactly one word, by +1.
- R6: A pass ends at the first sample whose sign differs from the reference sign. The pass keeps the words that were applied during that sample.
- R7: A pass also ends, with the words it currently has, when the word it would step already equals 63.
- R8: Final result.
  - Each final word is floor((first-pass word + second-pass word) / 2).
  - The final words appear together with a one-cycle done pulse, and busy is low in that cycle.
  - The final words hold in idle.
- R9: A start request made while busy is high has no effect on the result or on the run length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (accepted in idle only) |
| wait_len | input | 16 | Settle length W, latched at start |
| cmp_high | input | 1 | Averaged output is above mid-level |
| busy | output | 1 | Calibration passes in progress |
| done | output | 1 | One-cycle pulse when final words are loaded |
| dly_a | output | 6 | Delay word for the edge that opens sub-converter A's window |
| dly_b | output | 6 | Delay word for the edge that closes sub-converter A's window |
| force_a | output | 12 | Code forced onto sub-converter A |
| force_b | output | 12 | Code forced onto sub-converter B |

## Verification
The assertions check four things on every cycle:
- exactly one sub-converter is held at full scale while busy, and both are released in idle;
- the delay words never move during settling;
- every step within a pass changes exactly one word by one;
- the done pulse lasts one cycle.

Only the bench's scenarios can show the rest. The bench drives a comparator model with a different skew offset in each pass and sweeps those offsets and the settle length. Its scenarios show:
- where each pass stops, including at the flip and at saturation;
- the floor-averaged final words;
- the total run length;
- that a start request made during a run is ignored.

// File: rtl/skew_trim_pkg.sv
package skew_trim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_DONE
    } trim_state_e;

    typedef enum logic {
        PASS_FWD,
        PASS_SWP
    } trim_pass_e;
endpackage

// File: rtl/skew_settle_timer.sv
module skew_settle_timer #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [WAIT_W-1:0] limit,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt_q;

    assign expired = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: the count never runs past the latched settle length
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> cnt_q <= limit);
endmodule

// File: rtl/skew_code_avg.sv
module skew_code_avg #(
    parameter int CODE_W = 6,
    parameter int LANES  = 2
) (
    input  logic [LANES-1:0][CODE_W-1:0] first_pass,
    input  logic [LANES-1:0][CODE_W-1:0] second_pass,
    output logic [LANES-1:0][CODE_W-1:0] mean
);
    localparam int SUM_W = CODE_W + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SUM_W-1:0] sum;
        assign sum     = {1'b0, first_pass[g]} + {1'b0, second_pass[g]};
        assign mean[g] = sum[SUM_W-1:1];
    end
endmodule

// File: rtl/skew_trim_ctrl.sv
module skew_trim_ctrl
    import skew_trim_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int DAC_W  = 12,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_len,
    input  logic              cmp_high,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] dly_a,
    output logic [CODE_W-1:0] dly_b,
    output logic [DAC_W-1:0]  force_a,
    output logic [DAC_W-1:0]  force_b
);
    localparam logic [CODE_W-1:0] CODE_MID  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_TOP  = '1;
    localparam logic [DAC_W-1:0]  DAC_FULL  = '1;

    trim_state_e       state_q, state_d;
    trim_pass_e        pass_q;
    logic              first_q, ref_q;
    logic [CODE_W-1:0] code_a_q, code_b_q;
    logic [CODE_W-1:0] keep_a_q, keep_b_q;
    logic [WAIT_W-1:0] wait_q;
    logic              settle_done;
    logic              ref_eff, up_a, flipped, saturated, pass_end;
    logic [1:0][CODE_W-1:0] mean;

    skew_settle_timer #(.WAIT_W(WAIT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_SETTLE),
        .limit   (wait_q),
        .expired (settle_done)
    );

    skew_code_avg #(.CODE_W(CODE_W), .LANES(2)) i_avg (
        .first_pass  ({keep_b_q, keep_a_q}),
        .second_pass ({code_b_q, code_a_q}),
        .mean        (mean)
    );

    // Sample decision: which word moves, and whether the pass is over
    always_comb begin
        ref_eff   = first_q ? cmp_high : ref_q;
        up_a      = (pass_q == PASS_FWD) ? ref_eff : !ref_eff;
        flipped   = !first_q && (cmp_high != ref_q);
        saturated = up_a ? (code_a_q == CODE_TOP) : (code_b_q == CODE_TOP);
        pass_end  = flipped || saturated;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = (pass_end && pass_q == PASS_SWP) ? ST_DONE : ST_SETTLE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pass, sign and delay-word registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q   <= PASS_FWD;
            first_q  <= 1'b1;
            ref_q    <= 1'b0;
            code_a_q <= CODE_MID;
            code_b_q <= CODE_MID;
            keep_a_q <= CODE_MID;
            keep_b_q <= CODE_MID;
            wait_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pass_q   <= PASS_FWD;
                        first_q  <= 1'b1;
                        code_a_q <= CODE_MID;
                        code_b_q <= CODE_MID;
                        wait_q   <= wait_len;
                    end
                end
                ST_SAMPLE: begin
                    if (pass_end) begin
                        first_q <= 1'b1;
                        if (pass_q == PASS_FWD) begin
                            keep_a_q <= code_a_q;
                            keep_b_q <= code_b_q;
                            code_a_q <= CODE_MID;
                            code_b_q <= CODE_MID;
                            pass_q   <= PASS_SWP;
                        end else begin
                            code_a_q <= mean[0];
                            code_b_q <= mean[1];
                        end
                    end else begin
                        first_q <= 1'b0;
                        if (first_q) ref_q <= cmp_high;
                        if (up_a) code_a_q <= code_a_q + 1'b1;
                        else      code_b_q <= code_b_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q == ST_SETTLE) || (state_q == ST_SAMPLE);
        done    = (state_q == ST_DONE);
        dly_a   = code_a_q;
        dly_b   = code_b_q;
        force_a = (busy && pass_q == PASS_FWD) ? DAC_FULL : '0;
        force_b = (busy && pass_q == PASS_SWP) ? DAC_FULL : '0;
    end

    // R2: exactly one sub-converter held at full scale during a run
    p_force_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones({force_a == DAC_FULL, force_b == DAC_FULL}) == 1)
                 && (force_a == '0 || force_b == '0));

    // R2: both forced codes released outside a run
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (force_a == '0) && (force_b == '0));

    // R4: delay words are frozen while the average settles
    p_hold_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && $past(state_q) == ST_SETTLE)
        |-> $stable(code_a_q) && $stable(code_b_q));

    // R5: a step inside a pass moves exactly one word by +1
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && $past(state_q) == ST_SAMPLE && pass_q == $past(pass_q))
        |-> ((code_a_q - $past(code_a_q) == CODE_W'(1)) && $stable(code_b_q))
         || ((code_b_q - $past(code_b_q) == CODE_W'(1)) && $stable(code_a_q)));

    // R8: done is a single-cycle pulse followed by idle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
endmodule

// File: tb/test_skew_trim_ctrl.sv
module test_skew_trim_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] wait_len = '0;
    logic        cmp_high;
    logic        busy, done;
    logic [5:0]  dly_a, dly_b;
    logic [11:0] force_a, force_b;

    int n_checks = 0;
    int n_fail   = 0;
    int off_fwd  = 0;
    int off_swp  = 0;

    always #10 clk = ~clk;

    skew_trim_ctrl i_skew_trim_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wait_len (wait_len),
        .cmp_high (cmp_high),
        .busy     (busy),
        .done     (done),
        .dly_a    (dly_a),
        .dly_b    (dly_b),
        .force_a  (force_a),
        .force_b  (force_b)
    );

    // Averaged-level sign model: window of the forced-high converter vs half period
    always_comb begin
        if (force_a != '0) cmp_high = (int'(dly_b) - int'(dly_a) + off_fwd) > 0;
        else               cmp_high = (int'(dly_a) - int'(dly_b) + off_swp) > 0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Steps a pass takes for a given offset, capped at saturation (R6, R7)
    function automatic int pass_steps(input int off);
        int s = (off > 0) ? off : 1 - off;
        return (s > 31) ? 31 : s;
    endfunction

    task automatic run_case(input int o0, input int o1, input int w, input bit poke);
        int k0, k1, a0, b0, a1, b1, lat, last, exp_lat;
        bit force_ok, gap_ok, mid_ok;
        logic [5:0] pa, pb;
        off_fwd = o0;
        off_swp = o1;
        k0 = pass_steps(o0);
        k1 = pass_steps(o1);
        // R5: first pass high sign moves dly_a, low moves dly_b; second pass reversed
        a0 = (o0 > 0) ? 32 + k0 : 32;
        b0 = (o0 > 0) ? 32 : 32 + k0;
        b1 = (o1 > 0) ? 32 + k1 : 32;
        a1 = (o1 > 0) ? 32 : 32 + k1;
        exp_lat = (k0 + 1 + k1 + 1) * (w + 2) + 1;
        wait_len = 16'(w);
        pa = dly_a;
        pb = dly_b;
        force_ok = 1'b1;
        gap_ok = 1'b1;
        mid_ok = 1'b1;
        lat = 0;
        last = 1;
        start = 1'b1;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = (poke && (lat == 3)) ? 1'b1 : 1'b0;
            if (lat == 1 && (dly_a != 6'd32 || dly_b != 6'd32)) mid_ok = 1'b0;
            if (busy && !((force_a == 12'hFFF && force_b == 12'h0) ||
                          (force_a == 12'h0 && force_b == 12'hFFF))) force_ok = 1'b0;
            if (lat > 1 && (dly_a != pa || dly_b != pb)) begin
                if (lat - last != w + 2) gap_ok = 1'b0;
                last = lat;
            end
            pa = dly_a;
            pb = dly_b;
            if (done || lat > 5000) break;
        end
        check(mid_ok, "R3 pass start at mid-code", int'(dly_a), 32);
        check(force_ok, "R2 one converter forced high", int'(force_a), 4095);
        check(gap_ok, "R4 code change spacing", last, w + 2);
        check(lat == exp_lat, poke ? "R9 run length with stray start" : "R4 run length", lat, exp_lat);
        check(dly_a == 6'((a0 + a1) / 2), "R8 final dly_a (R6/R7 pass ends)", int'(dly_a), (a0 + a1) / 2);
        check(dly_b == 6'((b0 + b1) / 2), "R8 final dly_b (R6/R7 pass ends)", int'(dly_b), (b0 + b1) / 2);
        check(!busy, "R8 busy low with done", int'(busy), 0);
        @(negedge clk);
        check(!done && !busy, "R8 done single cycle", int'(done), 0);
        check(force_a == 12'h0 && force_b == 12'h0, "R2 forces released in idle", int'(force_a), 0);
        check(dly_a == 6'((a0 + a1) / 2) && dly_b == 6'((b0 + b1) / 2),
              "R8 result held in idle", int'(dly_a), (a0 + a1) / 2);
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dly_a == 6'd32 && dly_b == 6'd32, "R1 reset delay words", int'(dly_a), 32);
        check(!busy && !done, "R1 reset flags", int'(busy), 0);
        check(force_a == 12'h0 && force_b == 12'h0, "R1 reset forced codes", int'(force_a), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Sweep of offsets and settle lengths (R3..R6, R8)
        for (int w = 0; w <= 2; w += 2) begin
            for (int o0 = -5; o0 <= 5; o0++) begin
                for (int j = 0; j < 4; j++) begin
                    int o1 = (j == 0) ? -3 : (j == 1) ? 0 : (j == 2) ? 2 : 5;
                    run_case(o0, o1, w, 1'b0);
                end
            end
        end
        // R7: saturation in each direction of each pass
        run_case(40, -40, 1, 1'b0);
        run_case(-40, 40, 0, 1'b0);
        run_case(31, -30, 3, 1'b0);
        // R9: stray start during a run
        run_case(4, -2, 1, 1'b1);
        run_case(-3, 6, 0, 1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule